// File: doc/BRIEF.md
# Circular Instruction Prefetch Queue

This block is a small ring of instruction words between a memory-side refill engine and an instruction-consuming core. The refill engine is the only writer and pushes fetched words in whenever the queue has room. The core is the only reader and takes words out in arrival order. The head word is always visible at the read side, together with a valid flag. The current fill level is exported so that the refill engine can choose when to start a burst.

When the core asks for a word and none is present, the queue puts the core to sleep. An invalidate also puts the core to sleep, and it clears the whole queue in a single cycle. The first word that is accepted while the core sleeps releases it with a one-cycle wake pulse. The core then resumes on that word right away. It does not wait for the queue to fill up again.

Everything runs on one clock. The reset is active-low, asserted asynchronously and released synchronously.

Top module: `iq_prefetch_queue`

## Requirements
- R1: After reset, the occupancy reads 0, `q_empty` is 1, `q_full` is 0, `fill_ready` is 1, and `instr_valid`, `core_dozing` and `wake_pulse` are all 0.
- R2: Words are delivered on `instr_data` in the order they were written. This holds across pointer wrap-around at entry DEPTH-1 back to entry 0.
- R3: When DEPTH (default 32) entries are held, `q_full` is 1 and `fill_ready` is 0. Any further write is refused: the occupancy stays at DEPTH and the refused word never appears at the read side.
- R4: A take while the queue is empty and no write is accepted leaves `instr_valid` at 0 and the occupancy at 0.
- R5: One cycle after an accepted write, the occupancy rises by one. One cycle after an accepted take, it falls by one. When both happen in the same cycle, it is unchanged.
- R6: A `flush` pulse leaves the occupancy at 0 and `instr_valid` at 0 in the next cycle, even if a write is offered in the same cycle. It also sets `core_dozing` in that next cycle.
- R7: A take on an empty queue with no write accepted in that cycle sets `core_dozing` in the next cycle. While `core_dozing` is 1, the queue is empty.
- R8: The first write accepted while `core_dozing` is 1 produces `wake_pulse` high for exactly one cycle. That cycle is the one in which the new word is valid, and `core_dozing` is 0 in the same cycle.
- R9: After waking, the core can take the single new word at once, without waiting for further refills.
- R10: A write accepted while `core_dozing` is 0 does not raise `wake_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fill_valid | input | 1 | Refill engine offers a word |
| fill_data | input | WIDTH | Offered instruction word |
| fill_ready | output | 1 | Queue has room; a write is accepted when this and `fill_valid` are both 1 |
| flush | input | 1 | Invalidate all held words |
| take | input | 1 | Core consumes the head word |
| instr_valid | output | 1 | Head word is present |
| instr_data | output | WIDTH | Head word |
| core_dozing | output | 1 | Core is held asleep |
| wake_pulse | output | 1 | One-cycle release of the core |
| occupancy | output | CW | Number of held words, 0 to DEPTH |
| q_empty | output | 1 | Occupancy is 0 |
| q_full | output | 1 | Occupancy is DEPTH |

## Verification
The queue is tried with four patterns. A single word written into a sleeping queue separates a correct wake from a pulse that is late, too long or missing. A 32-word refill that starts with the pointers at a non-zero offset shows whether wrap-around keeps the order, and the write attempted while full shows whether refusal is handled. A stretch of simultaneous writes and takes shows whether the occupancy counter stays flat when both happen in one cycle. A flush issued together with an offered write shows whether the invalidate takes priority and whether a later refill still wakes the core.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [0:0] {
    CORE_RUN  = 1'b0,
    CORE_DOZE = 1'b1
  } core_state_e;
endpackage

// File: rtl/iq_store.sv
module iq_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Data array carries no reset; each entry is clock-enabled by its decode.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we && (waddr == AW'(i))) begin
        mem[i] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/iq_ptrs.sv
module iq_ptrs #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          flush,
  output logic          push_fire,
  output logic          pop_fire,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] count_d;
  logic          upd_en;

  assign empty     = (count == '0);
  assign full      = (count == LIMIT);
  assign push_fire = push_req && !full && !flush;
  assign pop_fire  = pop_req && !empty && !flush;
  assign upd_en    = push_fire || pop_fire || flush;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_fire) begin
        wr_ptr_d = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop_fire) begin
        rd_ptr_d = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      case ({push_fire, pop_fire})
        2'b10:   count_d = count + 1'b1;
        2'b01:   count_d = count - 1'b1;
        default: count_d = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (upd_en) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT); // R3
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_req && !flush) |=> (count == LIMIT)); // R3
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push_req && !flush) |=> (count == '0)); // R4
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R6
  AST_BOTH_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> (count == $past(count))); // R5
endmodule

// File: rtl/iq_doze.sv
module iq_doze
  import iq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push_fire,
  input  logic pop_req,
  input  logic empty,
  input  logic flush,
  output logic dozing,
  output logic wake
);
  core_state_e state_q, state_d;
  logic        wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    if (flush) begin
      state_d = CORE_DOZE;
    end else if (push_fire) begin
      wake_d  = (state_q == CORE_DOZE);
      state_d = CORE_RUN;
    end else if (pop_req && empty) begin
      state_d = CORE_DOZE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CORE_RUN;
      wake    <= 1'b0;
    end else begin
      state_q <= state_d;
      wake    <= wake_d;
    end
  end

  assign dozing = (state_q == CORE_DOZE);

  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake); // R8
  AST_WAKE_FROM_DOZE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ($past(dozing) && !dozing)); // R8
  AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !dozing) |=> !wake); // R10
endmodule

// File: rtl/iq_prefetch_queue.sv
module iq_prefetch_queue #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic [WIDTH-1:0] fill_data,
  output logic             fill_ready,
  input  logic             flush,
  input  logic             take,
  output logic             instr_valid,
  output logic [WIDTH-1:0] instr_data,
  output logic             core_dozing,
  output logic             wake_pulse,
  output logic [CW-1:0]    occupancy,
  output logic             q_empty,
  output logic             q_full
);
  logic          push_fire, pop_fire;
  logic [AW-1:0] wr_ptr, rd_ptr;

  iq_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (fill_valid),
    .pop_req   (take),
    .flush     (flush),
    .push_fire (push_fire),
    .pop_fire  (pop_fire),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (occupancy),
    .empty     (q_empty),
    .full      (q_full)
  );

  iq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (push_fire),
    .waddr (wr_ptr),
    .wdata (fill_data),
    .raddr (rd_ptr),
    .rdata (instr_data)
  );

  iq_doze u_doze (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_fire (push_fire),
    .pop_req   (take),
    .empty     (q_empty),
    .flush     (flush),
    .dozing    (core_dozing),
    .wake      (wake_pulse)
  );

  assign fill_ready  = !q_full;
  assign instr_valid = !q_empty;

  AST_DOZE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    core_dozing |-> !instr_valid); // R7
  AST_WAKE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> instr_valid); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> instr_valid); // R4
endmodule

// File: tb/sim_iq_prefetch_queue.sv
module sim_iq_prefetch_queue;
  localparam int W = 32;
  localparam int D = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fill_valid = 1'b0;
  logic [W-1:0] fill_data = '0;
  logic         flush = 1'b0;
  logic         take = 1'b0;
  logic         fill_ready, instr_valid, core_dozing, wake_pulse, q_empty, q_full;
  logic [W-1:0] instr_data;
  logic [5:0]   occupancy;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  iq_prefetch_queue #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_data(fill_data),
    .fill_ready(fill_ready), .flush(flush), .take(take),
    .instr_valid(instr_valid), .instr_data(instr_data),
    .core_dozing(core_dozing), .wake_pulse(wake_pulse),
    .occupancy(occupancy), .q_empty(q_empty), .q_full(q_full)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] v);
    fill_valid = 1'b1;
    fill_data  = v;
    tick();
    fill_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [W-1:0] v);
    chk({req, " valid"}, W'(instr_valid), 1);
    chk({req, " data"}, instr_data, v);
    take = 1'b1;
    tick();
    take = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 occ", W'(occupancy), 0);
    chk("R1 empty", W'(q_empty), 1);
    chk("R1 full", W'(q_full), 0);
    chk("R1 ready", W'(fill_ready), 1);
    chk("R1 valid", W'(instr_valid), 0);
    chk("R1 doze", W'(core_dozing), 0);
    chk("R1 wake", W'(wake_pulse), 0);
  endtask

  task automatic t_doze_wake();
    take = 1'b1;
    tick();
    chk("R4 valid", W'(instr_valid), 0);
    chk("R4 occ", W'(occupancy), 0);
    chk("R7 doze", W'(core_dozing), 1);
    tick();
    take = 1'b0;
    chk("R7 doze held", W'(core_dozing), 1);
    push(32'h0BAD_F00D);
    chk("R8 wake high", W'(wake_pulse), 1);
    chk("R8 doze clear", W'(core_dozing), 0);
    chk("R9 valid", W'(instr_valid), 1);
    chk("R9 data", instr_data, 32'h0BAD_F00D);
    tick();
    chk("R8 wake one cycle", W'(wake_pulse), 0);
    pop_expect("R9", 32'h0BAD_F00D);
    chk("R5 occ after pop", W'(occupancy), 0);
  endtask

  task automatic t_fill_wrap();
    bit woke = 1'b0;
    for (int i = 0; i < D; i++) begin
      push(32'hA500_0000 + W'(i));
      if (wake_pulse) woke = 1'b1;
    end
    chk("R10 no wake", W'(woke), 0);
    chk("R3 occ", W'(occupancy), D);
    chk("R3 full", W'(q_full), 1);
    chk("R3 ready", W'(fill_ready), 0);
    push(32'hDEAD_DEAD);
    chk("R3 refused occ", W'(occupancy), D);
    for (int i = 0; i < D; i++) begin
      pop_expect("R2", 32'hA500_0000 + W'(i));
    end
    chk("R3 refused word absent", W'(instr_valid), 0);
    chk("R5 drained", W'(occupancy), 0);
  endtask

  task automatic t_both();
    for (int i = 0; i < 3; i++) push(32'hC000_0000 + W'(i));
    chk("R5 occ3", W'(occupancy), 3);
    for (int i = 0; i < 5; i++) begin
      chk("R2 head", instr_data, 32'hC000_0000 + W'(i));
      fill_valid = 1'b1;
      fill_data  = 32'hC000_0003 + W'(i);
      take = 1'b1;
      tick();
      chk("R5 flat", W'(occupancy), 3);
    end
    fill_valid = 1'b0;
    take = 1'b0;
    pop_expect("R2 tail", 32'hC000_0005);
  endtask

  task automatic t_flush();
    fill_valid = 1'b1;
    fill_data  = 32'h1111_2222;
    flush = 1'b1;
    tick();
    flush = 1'b0;
    fill_valid = 1'b0;
    chk("R6 occ", W'(occupancy), 0);
    chk("R6 valid", W'(instr_valid), 0);
    chk("R6 doze", W'(core_dozing), 1);
    chk("R6 no wake", W'(wake_pulse), 0);
    push(32'h3333_4444);
    chk("R8 wake after flush", W'(wake_pulse), 1);
    pop_expect("R9 after flush", 32'h3333_4444);
    chk("R8 wake gone", W'(wake_pulse), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_doze_wake();
    t_fill_wrap();
    t_both();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule